// File: doc/BRIEF.md
# ROM Patch Address Remapper

This block sits between a processor address bus and its program ROMs and lets single aligned 8-byte ROM blocks be swapped for blocks held in a separate patch memory. A small table holds the upper address bits of each patched block and the number of the patch-memory block that replaces it. When a qualified bus access falls in a patched block, the block pulls an active-low patch flag. That flag turns off the normal address buffer and the ROM decoder and selects the patch memory. The block also drives the upper patch-memory address bits from the table. The lowest three address bits always pass straight through.

When no patch is active, the patch memory can still be reached directly through a fixed 2 KB window. The block also produces the enable for the read-data bus buffer. That enable is on only during reads, and it is held off when a forced-instruction fetch coincides with address bit 15 high.

Table entries are loaded through a valid/ready write port. Ready is held high at all times, so the port never applies back-pressure. Each accepted beat replaces one whole entry at the next clock edge. The match logic and every enable output are combinational from the current address and qualifier inputs.

Top module: `rom_patch_remap`

## Requirements
- R1: After reset every table entry is invalid, so `patch_flag_n` stays 1 for every address.
- R2: With all qualifiers true, an access whose address bits 15:3 equal the match field of a valid entry drives `patch_flag_n` to 0.
- R3: No patch is flagged while `vma` is 0, or `rom_dis_n` is 0, or `patch_jmp_norm` is 0.
- R4: During a patch, `patch_addr[10:3]` carries the winning entry's substitute block number and `patch_addr[2:0]` equals `cpu_addr[2:0]`.
- R5: While `patch_flag_n` is 0, `addr_buf_en` and `rom_dec_en` are 0 and `patch_cs` is 1. While `patch_flag_n` is 1, `addr_buf_en` and `rom_dec_en` are 1.
- R6: With no patch active, `patch_cs` is 1 exactly when `vma` is 1 and `cpu_addr` is in 0x9800..0x9FFF. In that case `patch_addr` equals `cpu_addr[10:0]`.
- R7: When several valid entries match, the entry with the lowest index supplies the substitute block number.
- R8: `data_buf_en` is 1 only when `rd` is 1 and it is not the case that both `forced_instr` and `cpu_addr[15]` are 1.
- R9: `tbl_wr_ready` is always 1. An entry written on a clock edge where `tbl_wr_valid` is 1 takes effect after that edge and not before it.
- R10: An entry written with its valid bit 0 never matches, whatever its match field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the table registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Processor address bus |
| vma | input | 1 | Valid memory access qualifier |
| rom_dis_n | input | 1 | ROM-disable line, 1 = normal operation |
| patch_jmp_norm | input | 1 | Patch enable jumper, 1 = normal position |
| rd | input | 1 | Read cycle indicator |
| forced_instr | input | 1 | Forced-instruction fetch indicator |
| tbl_wr_valid | input | 1 | Table write beat valid |
| tbl_wr_ready | output | 1 | Table write ready, always 1 |
| tbl_wr_idx | input | 3 | Entry index to write |
| tbl_wr_en | input | 1 | Valid bit for the written entry |
| tbl_wr_match | input | 13 | Address bits 15:3 the entry matches |
| tbl_wr_block | input | 8 | Substitute block number |
| patch_flag_n | output | 1 | Active-low patch hit flag |
| addr_buf_en | output | 1 | Normal address line buffer enable |
| rom_dec_en | output | 1 | Normal ROM address decoder enable |
| patch_cs | output | 1 | Patch memory chip select |
| patch_addr | output | 11 | Patch memory address |
| data_buf_en | output | 1 | Read-data bus buffer enable |

## Verification
The assertions take the table contents only as they are loaded through the write port, and they treat every address and qualifier input as free. The one input rule they depend on is that the write port is quiet whenever the combinational outputs are compared against a table state. The bench keeps to this by loading entries only at falling edges and dropping `tbl_wr_valid` before any sweep. It then walks the whole 64 K address space and every qualifier combination while the table is static. Its table model is updated only at the clock edge that accepts a write.

// File: rtl/rom_patch_pkg.sv
package rom_patch_pkg;
  localparam int ADDR_W    = 16;
  localparam int OFS_W     = 3;
  localparam int MATCH_W   = ADDR_W - OFS_W;
  localparam int SUB_W     = 8;
  localparam int PATCH_AW  = SUB_W + OFS_W;
  localparam int N_ENTRIES = 8;
  localparam int IDX_W     = $clog2(N_ENTRIES);
  localparam logic [ADDR_W-1:0] WIN_BASE = 16'h9800;
endpackage

// File: rtl/patch_table.sv
module patch_table #(
  parameter int N     = rom_patch_pkg::N_ENTRIES,
  parameter int MW    = rom_patch_pkg::MATCH_W,
  parameter int SW    = rom_patch_pkg::SUB_W,
  localparam int IW   = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [IW-1:0]      wr_idx,
  input  logic               wr_en,
  input  logic [MW-1:0]      wr_match,
  input  logic [SW-1:0]      wr_block,
  output logic [N-1:0]       ent_valid,
  output logic [N-1:0][MW-1:0] ent_match,
  output logic [N-1:0][SW-1:0] ent_block
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic sel;
    assign sel = wr_valid && (wr_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[g] <= 1'b0;
        ent_match[g] <= '0;
        ent_block[g] <= '0;
      end else if (sel) begin
        ent_valid[g] <= wr_en;
        ent_match[g] <= wr_match;
        ent_block[g] <= wr_block;
      end
    end
  end
endmodule

// File: rtl/patch_match.sv
module patch_match #(
  parameter int N  = rom_patch_pkg::N_ENTRIES,
  parameter int MW = rom_patch_pkg::MATCH_W,
  parameter int SW = rom_patch_pkg::SUB_W
) (
  input  logic [MW-1:0]        key,
  input  logic                 qual_ok,
  input  logic [N-1:0]         ent_valid,
  input  logic [N-1:0][MW-1:0] ent_match,
  input  logic [N-1:0][SW-1:0] ent_block,
  output logic                 hit,
  output logic [SW-1:0]        block
);
  logic [N-1:0] eq;
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = ent_valid[g] && (ent_match[g] == key);
  end

  // lowest index wins: scan from the top so lower entries overwrite
  always_comb begin
    block = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) block = ent_block[i];
    end
    hit = qual_ok && (|eq);
  end
endmodule

// File: rtl/patch_route.sv
module patch_route #(
  parameter int AW  = rom_patch_pkg::ADDR_W,
  parameter int OW  = rom_patch_pkg::OFS_W,
  parameter int SW  = rom_patch_pkg::SUB_W,
  parameter logic [AW-1:0] WIN = rom_patch_pkg::WIN_BASE,
  localparam int PW = SW + OW
) (
  input  logic [AW-1:0] cpu_addr,
  input  logic          vma,
  input  logic          rd,
  input  logic          forced_instr,
  input  logic          hit,
  input  logic [SW-1:0] block,
  output logic          patch_flag_n,
  output logic          addr_buf_en,
  output logic          rom_dec_en,
  output logic          patch_cs,
  output logic [PW-1:0] patch_addr,
  output logic          data_buf_en
);
  logic in_win;
  logic fi_gate;
  assign in_win  = vma && (cpu_addr[AW-1:PW] == WIN[AW-1:PW]);
  assign fi_gate = ~(forced_instr & cpu_addr[AW-1]);

  always_comb begin
    patch_flag_n = ~hit;
    addr_buf_en  = ~hit;
    rom_dec_en   = ~hit;
    patch_cs     = hit | in_win;
    patch_addr   = hit ? {block, cpu_addr[OW-1:0]} : cpu_addr[PW-1:0];
    data_buf_en  = rd & fi_gate;
  end
endmodule

// File: rtl/rom_patch_remap.sv
module rom_patch_remap
  import rom_patch_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic                vma,
  input  logic                rom_dis_n,
  input  logic                patch_jmp_norm,
  input  logic                rd,
  input  logic                forced_instr,
  input  logic                tbl_wr_valid,
  output logic                tbl_wr_ready,
  input  logic [IDX_W-1:0]    tbl_wr_idx,
  input  logic                tbl_wr_en,
  input  logic [MATCH_W-1:0]  tbl_wr_match,
  input  logic [SUB_W-1:0]    tbl_wr_block,
  output logic                patch_flag_n,
  output logic                addr_buf_en,
  output logic                rom_dec_en,
  output logic                patch_cs,
  output logic [PATCH_AW-1:0] patch_addr,
  output logic                data_buf_en
);
  logic [N_ENTRIES-1:0]              ent_valid;
  logic [N_ENTRIES-1:0][MATCH_W-1:0] ent_match;
  logic [N_ENTRIES-1:0][SUB_W-1:0]   ent_block;
  logic                              hit;
  logic [SUB_W-1:0]                  block;
  logic                              qual_ok;

  assign tbl_wr_ready = 1'b1;
  assign qual_ok = vma && rom_dis_n && patch_jmp_norm;

  patch_table #(.N(N_ENTRIES), .MW(MATCH_W), .SW(SUB_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(tbl_wr_valid && tbl_wr_ready), .wr_idx(tbl_wr_idx),
    .wr_en(tbl_wr_en), .wr_match(tbl_wr_match), .wr_block(tbl_wr_block),
    .ent_valid(ent_valid), .ent_match(ent_match), .ent_block(ent_block)
  );

  patch_match #(.N(N_ENTRIES), .MW(MATCH_W), .SW(SUB_W)) u_match (
    .key(cpu_addr[ADDR_W-1:OFS_W]), .qual_ok(qual_ok),
    .ent_valid(ent_valid), .ent_match(ent_match), .ent_block(ent_block),
    .hit(hit), .block(block)
  );

  patch_route #(.AW(ADDR_W), .OW(OFS_W), .SW(SUB_W), .WIN(WIN_BASE)) u_route (
    .cpu_addr(cpu_addr), .vma(vma), .rd(rd), .forced_instr(forced_instr),
    .hit(hit), .block(block),
    .patch_flag_n(patch_flag_n), .addr_buf_en(addr_buf_en),
    .rom_dec_en(rom_dec_en), .patch_cs(patch_cs),
    .patch_addr(patch_addr), .data_buf_en(data_buf_en)
  );
endmodule

// File: rtl/rom_patch_remap_chk.sv
module rom_patch_remap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        vma,
  input logic        rom_dis_n,
  input logic        patch_jmp_norm,
  input logic        rd,
  input logic        forced_instr,
  input logic        tbl_wr_ready,
  input logic        patch_flag_n,
  input logic        addr_buf_en,
  input logic        rom_dec_en,
  input logic        patch_cs,
  input logic [10:0] patch_addr,
  input logic        data_buf_en
);
  p_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!vma || !rom_dis_n || !patch_jmp_norm) |-> patch_flag_n);
  p_low_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !patch_flag_n |-> (patch_addr[2:0] == cpu_addr[2:0]));
  p_hit_gates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !patch_flag_n |-> (!addr_buf_en && !rom_dec_en && patch_cs));
  p_miss_gates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    patch_flag_n |-> (addr_buf_en && rom_dec_en));
  p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (patch_flag_n && vma && cpu_addr[15:11] == 5'b10011)
      |-> (patch_cs && patch_addr == cpu_addr[10:0]));
  p_no_write_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> !data_buf_en);
  p_fi_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (forced_instr && cpu_addr[15]) |-> !data_buf_en);
  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_ready);
endmodule

bind rom_patch_remap rom_patch_remap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .vma(vma),
  .rom_dis_n(rom_dis_n), .patch_jmp_norm(patch_jmp_norm), .rd(rd),
  .forced_instr(forced_instr), .tbl_wr_ready(tbl_wr_ready),
  .patch_flag_n(patch_flag_n), .addr_buf_en(addr_buf_en),
  .rom_dec_en(rom_dec_en), .patch_cs(patch_cs),
  .patch_addr(patch_addr), .data_buf_en(data_buf_en)
);

// File: tb/rom_patch_remap_tb.sv
module rom_patch_remap_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        vma = 1'b0, rom_dis_n = 1'b1, patch_jmp_norm = 1'b1;
  logic        rd = 1'b0, forced_instr = 1'b0;
  logic        tbl_wr_valid = 1'b0, tbl_wr_ready;
  logic [2:0]  tbl_wr_idx = '0;
  logic        tbl_wr_en = 1'b0;
  logic [12:0] tbl_wr_match = '0;
  logic [7:0]  tbl_wr_block = '0;
  logic        patch_flag_n, addr_buf_en, rom_dec_en, patch_cs, data_buf_en;
  logic [10:0] patch_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic        m_v [8];
  logic [12:0] m_m [8];
  logic [7:0]  m_s [8];

  always #10 clk = ~clk;

  rom_patch_remap u_dut (.*);

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h act=%h exp=%h", tag, cpu_addr, act, exp);
    end
  endtask

  task automatic check_point(string tag);
    logic hit = 0, win;
    logic [7:0] blk = '0;
    logic [10:0] pa;
    logic q = vma && rom_dis_n && patch_jmp_norm;
    for (int i = 7; i >= 0; i--)
      if (m_v[i] && m_m[i] == cpu_addr[15:3]) begin hit = q; blk = m_s[i]; end
    win = vma && cpu_addr >= 16'h9800 && cpu_addr <= 16'h9FFF;
    pa  = hit ? {blk, cpu_addr[2:0]} : cpu_addr[10:0];
    #1;
    cmp({tag, " flag"}, 32'(patch_flag_n), 32'(!hit));
    cmp({tag, " R5 addr_buf"}, 32'(addr_buf_en), 32'(!hit));
    cmp({tag, " R5 rom_dec"}, 32'(rom_dec_en), 32'(!hit));
    cmp({tag, " R6 cs"}, 32'(patch_cs), 32'(hit || win));
    cmp({tag, " R4 paddr"}, 32'(patch_addr), 32'(pa));
    cmp({tag, " R8 dbuf"}, 32'(data_buf_en),
        32'(rd && !(forced_instr && cpu_addr[15])));
  endtask

  task automatic wr(int idx, logic en, logic [12:0] m, logic [7:0] s);
    @(negedge clk);
    tbl_wr_valid = 1; tbl_wr_idx = 3'(idx); tbl_wr_en = en;
    tbl_wr_match = m; tbl_wr_block = s;
    @(posedge clk);
    m_v[idx] = en; m_m[idx] = m; m_s[idx] = s;
    @(negedge clk);
    tbl_wr_valid = 0;
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a < 65536; a++) begin
      cpu_addr = 16'(a);
      check_point(tag);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_m[i] = '0; m_s[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    vma = 1; rd = 1;
    cmp("R9 ready", 32'(tbl_wr_ready), 32'd1);
    sweep("R1 reset");
    wr(0, 1, 13'h0123, 8'h55);
    wr(1, 1, 13'h1FFF, 8'hAA);
    wr(2, 1, 13'h0123, 8'h11);
    wr(3, 1, 13'h1300, 8'h03);
    wr(4, 0, 13'h0400, 8'h77);
    wr(5, 1, 13'h0000, 8'hFF);
    sweep("R2 R7 R10 full");
    cpu_addr = 16'h091D; #1;
    cmp("R7 lowest wins", 32'(patch_addr), 32'h2AD);
    cpu_addr = 16'h2003; #1;
    cmp("R10 invalid entry", 32'(patch_flag_n), 32'd1);
    for (int q = 0; q < 32; q++) begin
      {vma, rom_dis_n, patch_jmp_norm, rd, forced_instr} = 5'(q);
      foreach (m_m[i]) begin
        cpu_addr = {m_m[i], 3'(i)};
        check_point("R3 R8 qual");
      end
      cpu_addr = 16'h9C05; check_point("R6 R8 window");
      cpu_addr = 16'hA000; check_point("R6 R8 outside");
    end
    vma = 1; rom_dis_n = 1; patch_jmp_norm = 1; rd = 1; forced_instr = 0;
    cpu_addr = 16'h091A;
    @(negedge clk);
    tbl_wr_valid = 1; tbl_wr_idx = 0; tbl_wr_en = 0;
    tbl_wr_match = 13'h0123; tbl_wr_block = 8'h55;
    #1;
    cmp("R9 before edge", 32'(patch_addr), 32'h2AA);
    @(posedge clk); m_v[0] = 0;
    @(negedge clk); tbl_wr_valid = 0;
    #1;
    cmp("R9 R7 after edge", 32'(patch_addr), 32'h08A);
    sweep("R10 after clear");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule